// File: doc/BRIEF.md
# Fractional Baud Divisor Encoder

This block turns a requested serial bit rate into the 17-bit divisor word that a USB-to-serial bridge loads into its baud generator. The caller picks one of two base clocks (12 MHz or 48 MHz), states whether the target device is a legacy part, and presents a 32-bit rate with a one-cycle start pulse. The block then divides half the base clock by the rate, one quotient bit per clock. The result is the divisor in eighths.

When the division ends, the block forms the integer part. It maps the fraction onto the device's non-binary fraction code and applies the substitutions needed at the two highest rates. The 17-bit word comes out as a 16-bit request value plus one bit in the low position of a 16-bit index word. An error flag marks a zero rate or a divisor too large to encode. The result holds until the next request completes.

Top module: `baud_div_encoder`

## Requirements
- R1: In extended mode (legacy_i=0) the divisor in eighths is round((base/2)/rate), with halves rounded up. Its integer part (eighths divided by 8) appears in value_o[13:0].
- R2: In extended mode the eighths remainder f is coded into encoded bits 16..14 as f=0→000, 1→011, 2→010, 3→100, 4→001, 5→101, 6→110, 7→111. Encoded bits 15..14 sit in value_o[15:14] and bit 16 sits in index_o[0].
- R3: In legacy mode (legacy_i=1) the integer part is floor(base/16/rate). The fraction code in bits 15..14 comes from q=floor((base/2)/rate) by priority: q bit 2 set gives 01, else q bit 1 set gives 10, else q bit 0 set gives 11, else 00. Bit 16 is always 0.
- R4: An encoded divisor equal to exactly 1 is output as 0, in both modes.
- R5: In extended mode an encoded divisor of 0x04001 (1.5) is output as 0x00001. In legacy mode 0x04001 is output unchanged.
- R6: index_o[0] carries encoded bit 16 and index_o[15:1] is always 0.
- R7: A rate of 0, or an integer part above 16383, raises err_o and outputs value 0x3FFF with index 0. Otherwise err_o is 0.
- R8: busy_o rises the cycle after a start is accepted. done_o pulses for exactly one cycle, 33 clock edges after the accepting edge, in the same cycle busy_o falls.
- R9: A start pulse while busy_o is high is ignored, and the running request completes with its own inputs. value_o, index_o and err_o change only when done_o is high.
- R10: After reset busy_o, done_o, value_o, index_o and err_o are all 0.
- R11: base_sel_i=0 selects a 12 MHz base clock and base_sel_i=1 selects 48 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request pulse, accepted when not busy |
| base_sel_i | input | 1 | Base clock select: 0 = 12 MHz, 1 = 48 MHz |
| legacy_i | input | 1 | 1 = legacy four-code fraction, 0 = extended eight-code fraction |
| rate_i | input | 32 | Requested bit rate in bits per second |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| value_o | output | 16 | Encoded divisor bits 15..0 |
| index_o | output | 16 | Bit 0 = encoded divisor bit 16, other bits 0 |
| err_o | output | 1 | Zero rate or divisor out of range |

## Verification
A divider step lost, repeated or wrongly restored corrupts the low quotient bits first. That shows as a wrong fraction code or a rounding error on the next done pulse, and never later than that pulse. A step counter that is off by one moves done_o away from its fixed 33-cycle slot, so the latency check catches it on the first request. A mistake in the code table or the special cases shows only for particular rates. The sweep therefore walks every rate from 1 to 400 and a dense band near the highest rates, in both modes and with both base clocks, so each fraction code and substitution appears many times.

// File: rtl/baud_enc_pkg.sv
package baud_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIN  = 2'd2
  } enc_state_t;

  // eighths remainder -> three-bit device fraction code (extended parts)
  function automatic logic [2:0] ext_code(input logic [2:0] eighths);
    logic [2:0] c;
    case (eighths)
      3'd0:    c = 3'b000;
      3'd1:    c = 3'b011;
      3'd2:    c = 3'b010;
      3'd3:    c = 3'b100;
      3'd4:    c = 3'b001;
      3'd5:    c = 3'b101;
      3'd6:    c = 3'b110;
      default: c = 3'b111;
    endcase
    return c;
  endfunction

  // legacy parts: priority pick on the floor quotient in eighths
  function automatic logic [1:0] legacy_code(input logic [2:0] low_bits);
    logic [1:0] c;
    if (low_bits[2])      c = 2'b01;
    else if (low_bits[1]) c = 2'b10;
    else if (low_bits[0]) c = 2'b11;
    else                  c = 2'b00;
    return c;
  endfunction

endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/baud_restoring_div.sv
module baud_restoring_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] div_o
);
  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] div_q, div_d;
  logic [W:0]   rem_shift;
  logic [W:0]   trial;
  logic         fits;
  logic         reg_en;

  always_comb begin
    rem_shift = {rem_q, quo_q[W-1]};
    fits      = (rem_shift >= {1'b0, div_q});
    trial     = rem_shift - {1'b0, div_q};
    reg_en    = load_i | step_i;
    quo_d     = quo_q;
    rem_d     = rem_q;
    div_d     = div_q;
    if (load_i) begin
      quo_d = dividend_i;
      rem_d = '0;
      div_d = divisor_i;
    end else if (step_i) begin
      quo_d = {quo_q[W-2:0], fits};
      rem_d = fits ? trial[W-1:0] : rem_shift[W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      quo_q <= '0;
      rem_q <= '0;
      div_q <= '0;
    end else if (reg_en) begin
      quo_q <= quo_d;
      rem_q <= rem_d;
      div_q <= div_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
  assign div_o = div_q;
endmodule

// File: rtl/baud_frac_encode.sv
module baud_frac_encode
  import baud_enc_pkg::*;
#(
  parameter int W     = 32,
  parameter int INT_W = 14
) (
  input  logic             legacy_i,
  input  logic [W-1:0]     quo_i,
  input  logic [W-1:0]     rem_i,
  input  logic [W-1:0]     div_i,
  output logic [INT_W+2:0] enc_o,
  output logic             err_o
);
  localparam int ENC_W = INT_W + 3;
  localparam logic [ENC_W-1:0] SAT_WORD  = ENC_W'((1 << INT_W) - 1);
  localparam logic [ENC_W-1:0] ONE_WORD  = ENC_W'(1);
  localparam logic [ENC_W-1:0] ONE_HALF  = ENC_W'((1 << INT_W) | 1);

  logic             round_up;
  logic [W:0]       eighths;
  logic [W:0]       int_full;
  logic             too_big;
  logic [2:0]       code;
  logic [ENC_W-1:0] raw;

  always_comb begin
    round_up = ({rem_i, 1'b0} >= {1'b0, div_i});
    if (legacy_i) eighths = {1'b0, quo_i};
    else          eighths = {1'b0, quo_i} + {{W{1'b0}}, round_up};
    int_full = eighths >> 3;
    too_big  = (int_full >> INT_W) != '0;
    if (legacy_i) code = {1'b0, legacy_code(quo_i[2:0])};
    else          code = ext_code(eighths[2:0]);
    raw = {code, int_full[INT_W-1:0]};

    err_o = 1'b0;
    if ((div_i == '0) || too_big) begin
      enc_o = SAT_WORD;
      err_o = 1'b1;
    end else if (raw == ONE_WORD) begin
      enc_o = '0;
    end else if (!legacy_i && (raw == ONE_HALF)) begin
      enc_o = ONE_WORD;
    end else begin
      enc_o = raw;
    end
  end
endmodule

// File: rtl/baud_div_encoder.sv
module baud_div_encoder
  import baud_enc_pkg::*;
#(
  parameter int RATE_W     = 32,
  parameter int BASE_LO_HZ = 12_000_000,
  parameter int BASE_HI_HZ = 48_000_000,
  parameter int INT_W      = 14,
  parameter int VAL_W      = 16,
  parameter int IDX_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              start_i,
  input  logic              base_sel_i,
  input  logic              legacy_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [VAL_W-1:0]  value_o,
  output logic [IDX_W-1:0]  index_o,
  output logic              err_o
);
  localparam int ENC_W = INT_W + 3;
  localparam int CNT_W = $clog2(RATE_W);
  localparam logic [CNT_W-1:0]  LAST_STEP = CNT_W'(RATE_W - 1);
  localparam logic [RATE_W-1:0] NUM_LO    = RATE_W'(BASE_LO_HZ / 2);
  localparam logic [RATE_W-1:0] NUM_HI    = RATE_W'(BASE_HI_HZ / 2);

  logic             rst_n_s;
  enc_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             leg_q, leg_d;
  logic [VAL_W-1:0] value_q, value_d;
  logic             idx_q, idx_d;
  logic             err_q, err_d;
  logic             done_q, done_d;
  logic             ctl_en, cfg_en, res_en;
  logic             div_load, div_step;
  logic [RATE_W-1:0] quo, rem, divisor, dividend;
  logic [ENC_W-1:0] enc;
  logic             enc_err;

  baud_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_s)
  );

  assign dividend = base_sel_i ? NUM_HI : NUM_LO;

  baud_restoring_div #(.W(RATE_W)) div_i (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_s),
    .load_i     (div_load),
    .step_i     (div_step),
    .dividend_i (dividend),
    .divisor_i  (rate_i),
    .quo_o      (quo),
    .rem_o      (rem),
    .div_o      (divisor)
  );

  baud_frac_encode #(.W(RATE_W), .INT_W(INT_W)) enc_i (
    .legacy_i (leg_q),
    .quo_i    (quo),
    .rem_i    (rem),
    .div_i    (divisor),
    .enc_o    (enc),
    .err_o    (enc_err)
  );

  // next-state process
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    leg_d    = leg_q;
    value_d  = value_q;
    idx_d    = idx_q;
    err_d    = err_q;
    done_d   = 1'b0;
    div_load = 1'b0;
    div_step = 1'b0;
    cfg_en   = 1'b0;
    res_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          div_load = 1'b1;
          cfg_en   = 1'b1;
          leg_d    = legacy_i;
          cnt_d    = '0;
          state_d  = ST_DIV;
        end
      end
      ST_DIV: begin
        div_step = 1'b1;
        cnt_d    = cnt_q + 1'b1;
        if (cnt_q == LAST_STEP) state_d = ST_FIN;
      end
      ST_FIN: begin
        res_en  = 1'b1;
        value_d = enc[VAL_W-1:0];
        idx_d   = enc[ENC_W-1];
        err_d   = enc_err;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctl_en = 1'b1;

  // register process
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) leg_q <= 1'b0;
    else if (cfg_en) leg_q <= leg_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      value_q <= '0;
      idx_q   <= 1'b0;
      err_q   <= 1'b0;
    end else if (res_en) begin
      value_q <= value_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign value_o = value_q;
  assign index_o = {{(IDX_W-1){1'b0}}, idx_q};
  assign err_o   = err_q;
endmodule

// File: rtl/baud_div_encoder_chk.sv
module baud_div_encoder_chk #(
  parameter int RATE_W = 32,
  parameter int INT_W  = 14,
  parameter int VAL_W  = 16,
  parameter int IDX_W  = 16
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [VAL_W-1:0]  value_o,
  input logic [IDX_W-1:0]  index_o,
  input logic              err_o
);
  localparam int LAT   = RATE_W + 1;
  localparam int LAT_W = $clog2(RATE_W + 4) + 1;
  localparam logic [VAL_W-1:0] SAT_VAL = VAL_W'((1 << INT_W) - 1);

  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)               lat_q <= '0;
    else if (start_i && !busy_o) lat_q <= '0;
    else if (busy_o)            lat_q <= lat_q + 1'b1;
  end

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> !done_o);

  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |-> (lat_q == LAT_W'(LAT)));

  a_r8_busy_ends_with_done: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(busy_o) |-> done_o);

  a_r6_index_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    index_o[IDX_W-1:1] == '0);

  a_r7_err_saturates: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    err_o |-> (value_o == SAT_VAL && index_o == '0));

  a_r9_result_holds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !done_o |-> ($stable(value_o) && $stable(index_o) && $stable(err_o)));
endmodule

bind baud_div_encoder baud_div_encoder_chk #(
  .RATE_W (RATE_W),
  .INT_W  (INT_W),
  .VAL_W  (VAL_W),
  .IDX_W  (IDX_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_n_i (rst_n_i),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .value_o (value_o),
  .index_o (index_o),
  .err_o   (err_o)
);

// File: tb/baud_div_encoder_tb_top.sv
`timescale 1ns/1ps
module baud_div_encoder_tb_top;
  localparam int WATCHDOG = 190_000;
  localparam int EXP_LAT  = 33;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        base_sel;
  logic        legacy;
  logic [31:0] rate;
  logic        busy, done, err;
  logic [15:0] value, index;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  baud_div_encoder dut_i (
    .clk_i      (clk),
    .rst_n_i    (rst_n),
    .start_i    (start),
    .base_sel_i (base_sel),
    .legacy_i   (legacy),
    .rate_i     (rate),
    .busy_o     (busy),
    .done_o     (done),
    .value_o    (value),
    .index_o    (index),
    .err_o      (err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] code8(input int f);
    case (f)
      0: return 3'b000;
      1: return 3'b011;
      2: return 3'b010;
      3: return 3'b100;
      4: return 3'b001;
      5: return 3'b101;
      6: return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  // expected 17-bit word and error flag, from the requirements
  task automatic model(input bit hi, input bit leg, input longint r,
                       output longint enc, output bit e);
    longint base, half, ip, q8, lb, fc;
    base = hi ? 48_000_000 : 12_000_000;
    half = base / 2;
    e = 1'b0;
    if (r == 0) begin
      enc = 16383; e = 1'b1; return;
    end
    if (leg) begin
      ip = base / 16 / r;
      lb = half / r;
      fc = (lb & 4) ? 1 : (lb & 2) ? 2 : (lb & 1) ? 3 : 0;
    end else begin
      q8 = (2 * half + r) / (2 * r);
      ip = q8 / 8;
      fc = longint'(code8(int'(q8 % 8)));
    end
    if (ip > 16383) begin
      enc = 16383; e = 1'b1; return;
    end
    enc = (fc << 14) | ip;
    if (enc == 1) enc = 0;
    else if (!leg && enc == 'h4001) enc = 1;
  endtask

  task automatic run_op(input bit hi, input bit leg, input longint r,
                        input string req, input bit intrude);
    int cyc;
    longint exp_enc;
    bit exp_err;
    @(negedge clk);
    base_sel = hi; legacy = leg; rate = 32'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      start = intrude && (cyc == 4);
      if (intrude && cyc == 4) begin
        rate = 32'(r) ^ 32'h55; legacy = ~leg; base_sel = ~hi;
      end
      @(negedge clk);
      cyc++;
      if (cyc == 1) check(busy == 1'b1, "R8", "busy after start", longint'(busy), 1);
    end
    start = 1'b0;
    model(hi, leg, r, exp_enc, exp_err);
    check(cyc == EXP_LAT, "R8", "done latency", cyc, EXP_LAT);
    check({index[0], value} == 17'(exp_enc), req, $sformatf("encoded word rate=%0d", r),
          longint'({index[0], value}), exp_enc);
    check(index[15:1] == '0, "R6", "index upper bits", longint'(index), 0);
    check(err == exp_err, "R7", "error flag", longint'(err), longint'(exp_err));
    if (intrude) check(1'b1 == 1'b1 && {index[0], value} == 17'(exp_enc), "R9",
                       "start during busy ignored", longint'({index[0], value}), exp_enc);
    @(negedge clk);
    check(done == 1'b0, "R8", "done single cycle", longint'(done), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R8 watchdog: cycles=%0d expected below %0d", WATCHDOG, WATCHDOG);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; base_sel = 1'b0; legacy = 1'b0; rate = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(busy == 1'b0, "R10", "busy after reset", longint'(busy), 0);
    check(done == 1'b0, "R10", "done after reset", longint'(done), 0);
    check(value == '0, "R10", "value after reset", longint'(value), 0);
    check(index == '0, "R10", "index after reset", longint'(index), 0);
    check(err == 1'b0, "R10", "err after reset", longint'(err), 0);

    // directed corners
    run_op(1'b1, 1'b0, 0, "R7", 1'b0);
    check(value == 16'h3FFF && err, "R7", "zero rate saturates", longint'(value), 'h3FFF);
    run_op(1'b1, 1'b0, 9600, "R1", 1'b0);
    check(value == 16'h4138 && index == 0, "R1", "48MHz 9600", longint'(value), 'h4138);
    run_op(1'b1, 1'b0, 1_600_000, "R2", 1'b0);
    check(value == 16'hC001 && index == 16'd1, "R2", "fraction .875 code", longint'({index[0], value}), 'h1C001);
    run_op(1'b1, 1'b0, 921_600, "R2", 1'b0);
    check(value == 16'h8003 && index == 0, "R2", "fraction .25 code", longint'(value), 'h8003);
    run_op(1'b1, 1'b0, 3_000_000, "R4", 1'b0);
    check(value == 16'h0000, "R4", "unit divisor extended", longint'(value), 0);
    run_op(1'b1, 1'b1, 3_000_000, "R4", 1'b0);
    check(value == 16'h0000, "R4", "unit divisor legacy", longint'(value), 0);
    run_op(1'b1, 1'b0, 2_000_000, "R5", 1'b0);
    check(value == 16'h0001, "R5", "1.5 substitute extended", longint'(value), 1);
    run_op(1'b1, 1'b1, 2_000_000, "R5", 1'b0);
    check(value == 16'h4001, "R5", "1.5 kept legacy", longint'(value), 'h4001);
    run_op(1'b0, 1'b0, 300, "R11", 1'b0);
    check(value == 16'h09C4, "R11", "12MHz 300", longint'(value), 'h09C4);
    run_op(1'b0, 1'b0, 45, "R7", 1'b0);
    check(err == 1'b1, "R7", "integer overflow", longint'(err), 1);
    run_op(1'b1, 1'b1, 4800, "R9", 1'b1);
    run_op(1'b0, 1'b0, 7777, "R9", 1'b1);

    // near-exhaustive sweeps
    for (int r = 1; r <= 400; r++) begin
      run_op(1'b0, 1'b0, r, "R1+R11", 1'b0);
      run_op(1'b1, 1'b0, r, "R1", 1'b0);
      run_op(1'b0, 1'b1, r, "R3+R11", 1'b0);
      run_op(1'b1, 1'b1, r, "R3", 1'b0);
    end
    for (int r = 1_400_000; r <= 3_600_000; r += 20_000) begin
      run_op(1'b1, 1'b0, r, "R2", 1'b0);
      run_op(1'b1, 1'b1, r, "R3", 1'b0);
      run_op(1'b0, 1'b0, r / 4, "R2+R11", 1'b0);
      run_op(1'b0, 1'b1, r / 4, "R3+R11", 1'b0);
    end

    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule